// File: doc/BRIEF.md
# Configurable Chain or Tree ALU

This block is the arithmetic and logic unit of a small RISC core. It has nine functional units: an adder/subtractor, AND, OR, XOR, NOT, single-bit rotates left and right, and single-bit rotates left and right through the carry. Each cycle the block takes an opcode, two operands and a carry-in. One clock edge later it presents the registered result together with carry, zero, negative and overflow flags.

The structure that picks the winning unit's output is chosen at build time. It is either a balanced binary tree of 2:1 multiplexers indexed by the unit number, or a priority chain of 2:1 stages. Each stage of the chain tests for one unit and otherwise passes on the output of the stage behind it. The chain order is a parameter, so profiling can move the busiest units next to the output. An optional operand-isolation mode freezes the inputs of every idle unit at their last used value, so that idle logic does not switch.

Top module: `alu_core`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. On a cycle with `in_valid` low, the result and all four flags keep their previous values.
- R2: Opcode 0 (add) gives `a + b + cin` modulo 2^W. C is the carry out of the top bit. V is set when both operands have the same sign and the result's sign differs from it.
- R3: Opcode 1 (subtract) gives `a - b` and ignores `cin`. C is 1 when no borrow occurs (a >= b unsigned). V is set when the operand signs differ and the result's sign differs from the sign of `a`.
- R4: Opcodes 2 (AND), 3 (OR), 4 (XOR) and 5 (NOT of `a`) give the bitwise result and clear C and V.
- R5: Opcode 6 rotates `a` right by one place and opcode 8 rotates it left by one place. Both clear C and V.
- R6: Opcode 7 shifts `a` right by one and places `cin` in the top bit, with C = old bit 0. Opcode 9 shifts `a` left by one and places `cin` in bit 0, with C = old top bit. V is cleared for both.
- R7: For every opcode from 0 to 9, Z is 1 exactly when the result is zero, and N equals the top bit of the result.
- R8: Opcodes 10 to 15 are undefined. They give a zero result with all four flags cleared.
- R9: The tree build and chain builds with any unit order give identical results and flags for every opcode and operand.
- R10: With isolation enabled, the operands seen by a unit stay constant on every cycle in which that unit is not selected. Isolation does not change results or flags.
- R11: While reset is asserted, `out_valid`, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode, 0 to 9 defined |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry input |
| out_valid | output | 1 | Result registered from the previous cycle |
| result | output | W | Registered result |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench builds three copies at W = 16 and feeds them identical stimulus. The first is a chain in the default order with isolation on. The second is a tree with isolation off. The third is a chain in reversed order with isolation off, so its fall-through stage is the adder rather than rotate-left-through-carry. Each copy is compared with a reference model. This covers tree-versus-chain equivalence, order independence, and the requirement that isolation leaves results unchanged. Directed operands hit carry, borrow, signed overflow and zero results. Random opcodes, including undefined ones, arrive both back to back and with idle gaps between them.

// File: rtl/alu_cfg_pkg.sv
package alu_cfg_pkg;

    localparam int OPC_W     = 4;
    localparam int UNIT_W    = 4;
    localparam int NUM_UNITS = 9;

    // opcode encoding
    localparam logic [OPC_W-1:0] OP_ADD  = 4'd0;
    localparam logic [OPC_W-1:0] OP_SUB  = 4'd1;
    localparam logic [OPC_W-1:0] OP_AND  = 4'd2;
    localparam logic [OPC_W-1:0] OP_OR   = 4'd3;
    localparam logic [OPC_W-1:0] OP_XOR  = 4'd4;
    localparam logic [OPC_W-1:0] OP_NOT  = 4'd5;
    localparam logic [OPC_W-1:0] OP_ROR  = 4'd6;
    localparam logic [OPC_W-1:0] OP_RORC = 4'd7;
    localparam logic [OPC_W-1:0] OP_ROL  = 4'd8;
    localparam logic [OPC_W-1:0] OP_ROLC = 4'd9;

    // functional unit numbering (leaf index in tree mode)
    localparam int U_ADD  = 0;
    localparam int U_AND  = 1;
    localparam int U_ROR  = 2;
    localparam int U_OR   = 3;
    localparam int U_XOR  = 4;
    localparam int U_NOT  = 5;
    localparam int U_RORC = 6;
    localparam int U_ROL  = 7;
    localparam int U_ROLC = 8;

    localparam logic [UNIT_W-1:0] U_NONE = '1;

    function automatic logic [UNIT_W-1:0] unit_of(input logic [OPC_W-1:0] opc);
        case (opc)
            OP_ADD, OP_SUB: unit_of = UNIT_W'(U_ADD);
            OP_AND:         unit_of = UNIT_W'(U_AND);
            OP_OR:          unit_of = UNIT_W'(U_OR);
            OP_XOR:         unit_of = UNIT_W'(U_XOR);
            OP_NOT:         unit_of = UNIT_W'(U_NOT);
            OP_ROR:         unit_of = UNIT_W'(U_ROR);
            OP_RORC:        unit_of = UNIT_W'(U_RORC);
            OP_ROL:         unit_of = UNIT_W'(U_ROL);
            OP_ROLC:        unit_of = UNIT_W'(U_ROLC);
            default:        unit_of = U_NONE;
        endcase
    endfunction

    function automatic logic op_legal(input logic [OPC_W-1:0] opc);
        op_legal = (opc <= OP_ROLC);
    endfunction

endpackage

// File: rtl/alu_isolate.sv
module alu_isolate #(
    parameter int WIDTH  = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] hold_d, hold_q;

    always_comb begin
        dout   = (ENABLE && !en) ? hold_q : din;
        hold_d = dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    if (ENABLE) begin : g_chk
        // R10: an unselected unit sees no operand change
        p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> $stable(dout));
    end

endmodule

// File: rtl/alu_units.sv
module alu_units
    import alu_cfg_pkg::*;
#(
    parameter int W       = 16,
    parameter bit ISOLATE = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [OPC_W-1:0]                op,
    input  logic [W-1:0]                    a,
    input  logic [W-1:0]                    b,
    input  logic                            cin,
    output logic [NUM_UNITS-1:0][W+1:0]     unit_out
);

    logic is_sub;
    assign is_sub = (op == OP_SUB);

    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
        logic en;
        assign en = in_valid && (unit_of(op) == UNIT_W'(k));

        if (k == U_ADD) begin : g_add
            logic [2*W+1:0] opnd;
            logic [W-1:0]   oa, ob;
            logic           osub, ocin, ovf;
            logic [W:0]     sum;
            alu_isolate #(.WIDTH(2*W+2), .ENABLE(ISOLATE)) u_iso (
                .clk(clk), .rst_n(rst_n), .en(en),
                .din({is_sub, cin, a, b}), .dout(opnd));
            always_comb begin
                {osub, ocin, oa, ob} = opnd;
                if (osub) begin
                    sum = {1'b0, oa} + {1'b0, ~ob} + (W+1)'(1);
                    ovf = (oa[W-1] != ob[W-1]) && (sum[W-1] != oa[W-1]);
                end else begin
                    sum = {1'b0, oa} + {1'b0, ob} + (W+1)'(ocin);
                    ovf = (oa[W-1] == ob[W-1]) && (sum[W-1] != oa[W-1]);
                end
            end
            assign unit_out[k] = {sum[W], ovf, sum[W-1:0]};
        end else if (k == U_AND || k == U_OR || k == U_XOR) begin : g_logic
            logic [2*W-1:0] opnd;
            logic [W-1:0]   res;
            alu_isolate #(.WIDTH(2*W), .ENABLE(ISOLATE)) u_iso (
                .clk(clk), .rst_n(rst_n), .en(en),
                .din({a, b}), .dout(opnd));
            always_comb begin
                if (k == U_AND)     res = opnd[2*W-1:W] & opnd[W-1:0];
                else if (k == U_OR) res = opnd[2*W-1:W] | opnd[W-1:0];
                else                res = opnd[2*W-1:W] ^ opnd[W-1:0];
            end
            assign unit_out[k] = {2'b00, res};
        end else if (k == U_NOT || k == U_ROR || k == U_ROL) begin : g_single
            logic [W-1:0] opnd;
            logic [W-1:0] res;
            alu_isolate #(.WIDTH(W), .ENABLE(ISOLATE)) u_iso (
                .clk(clk), .rst_n(rst_n), .en(en),
                .din(a), .dout(opnd));
            always_comb begin
                if (k == U_NOT)      res = ~opnd;
                else if (k == U_ROR) res = {opnd[0], opnd[W-1:1]};
                else                 res = {opnd[W-2:0], opnd[W-1]};
            end
            assign unit_out[k] = {2'b00, res};
        end else begin : g_thru_carry
            logic [W:0]   opnd;
            logic [W-1:0] res;
            logic         cout;
            alu_isolate #(.WIDTH(W+1), .ENABLE(ISOLATE)) u_iso (
                .clk(clk), .rst_n(rst_n), .en(en),
                .din({cin, a}), .dout(opnd));
            always_comb begin
                if (k == U_RORC) begin
                    res  = {opnd[W], opnd[W-1:1]};
                    cout = opnd[0];
                end else begin
                    res  = {opnd[W-2:0], opnd[W]};
                    cout = opnd[W-1];
                end
            end
            assign unit_out[k] = {cout, 1'b0, res};
        end
    end

endmodule

// File: rtl/alu_select.sv
module alu_select
    import alu_cfg_pkg::*;
#(
    parameter int DW        = 18,
    parameter bit MODE_TREE = 1'b0,
    parameter logic [NUM_UNITS*UNIT_W-1:0] CHAIN_ORDER = 36'h876543210
) (
    input  logic [UNIT_W-1:0]              sel,
    input  logic [NUM_UNITS-1:0][DW-1:0]   din,
    output logic [DW-1:0]                  dout
);

    localparam int LVL    = $clog2(NUM_UNITS);
    localparam int LEAVES = 1 << LVL;

    if (MODE_TREE) begin : g_tree
        // heap-ordered nodes: node 1 is the root, leaves start at LEAVES
        logic [DW-1:0] node [1:2*LEAVES-1];
        for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
            if (i < NUM_UNITS) begin : g_used
                assign node[LEAVES+i] = din[i];
            end else begin : g_pad
                assign node[LEAVES+i] = '0;
            end
        end
        for (genvar i = 1; i < LEAVES; i++) begin : g_node
            localparam int DEPTH = $clog2(i + 1) - 1;
            assign node[i] = sel[LVL-1-DEPTH] ? node[2*i+1] : node[2*i];
        end
        assign dout = node[1];
    end else begin : g_chain
        // stage 0 drives the output; the last stage is the fall-through
        logic [DW-1:0] stage [NUM_UNITS];
        for (genvar k = 0; k < NUM_UNITS; k++) begin : g_stage
            localparam int UID = int'(CHAIN_ORDER[k*UNIT_W +: UNIT_W]);
            if (k == NUM_UNITS - 1) begin : g_last
                assign stage[k] = din[UID];
            end else begin : g_mid
                assign stage[k] = (sel == UNIT_W'(UID)) ? din[UID] : stage[k+1];
            end
        end
        assign dout = stage[0];
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_cfg_pkg::*;
#(
    parameter int W        = 16,
    parameter bit TREE_SEL = 1'b0,
    parameter logic [NUM_UNITS*UNIT_W-1:0] CHAIN_ORDER = 36'h876543210,
    parameter bit ISOLATE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPC_W-1:0] op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             cin,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             flag_c,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_v
);

    localparam int DW = W + 2;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         c;
        logic         z;
        logic         n;
        logic         v;
    } state_t;

    logic [NUM_UNITS-1:0][DW-1:0] unit_out;
    logic [DW-1:0]                picked;
    state_t                       st_d, st_q;

    alu_units #(.W(W), .ISOLATE(ISOLATE)) u_units (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a(a), .b(b), .cin(cin), .unit_out(unit_out));

    alu_select #(.DW(DW), .MODE_TREE(TREE_SEL), .CHAIN_ORDER(CHAIN_ORDER)) u_select (
        .sel(unit_of(op)), .din(unit_out), .dout(picked));

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (op_legal(op)) begin
                st_d.res = picked[W-1:0];
                st_d.c   = picked[W+1];
                st_d.v   = picked[W];
                st_d.z   = (picked[W-1:0] == '0);
                st_d.n   = picked[W-1];
            end else begin
                st_d.res = '0;
                st_d.c   = 1'b0;
                st_d.v   = 1'b0;
                st_d.z   = 1'b0;
                st_d.n   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flag_c    = st_q.c;
    assign flag_z    = st_q.z;
    assign flag_n    = st_q.n;
    assign flag_v    = st_q.v;

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({result, flag_c, flag_z, flag_n, flag_v}));
    p_logic_cv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= OP_AND && op <= OP_NOT) |=> (!flag_c && !flag_v));
    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_legal(op)) |=> (flag_z == (result == '0)) && (flag_n == result[W-1]));
    p_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_legal(op)) |=> (result == '0) && !flag_c && !flag_z && !flag_n && !flag_v);

endmodule

// File: tb/alu_core_bench.sv
module alu_core_bench;
    import alu_cfg_pkg::*;

    localparam int W  = 16;
    localparam int OW = W + 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [OPC_W-1:0] op = '0;
    logic [W-1:0]     a = '0, b = '0;
    logic             cin = 1'b0;

    logic         ov0, ov1, ov2;
    logic [W-1:0] r0, r1, r2;
    logic         c0, z0, n0, v0, c1, z1, n1, v1, c2, z2, n2, v2;

    always #5 clk = ~clk;

    // chain, default order, isolation on
    alu_core #(.W(W), .TREE_SEL(1'b0), .ISOLATE(1'b1)) u_alu_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b), .cin(cin),
        .out_valid(ov0), .result(r0), .flag_c(c0), .flag_z(z0), .flag_n(n0), .flag_v(v0));
    // tree, isolation off
    alu_core #(.W(W), .TREE_SEL(1'b1), .ISOLATE(1'b0)) u_alu_core_tree (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b), .cin(cin),
        .out_valid(ov1), .result(r1), .flag_c(c1), .flag_z(z1), .flag_n(n1), .flag_v(v1));
    // chain, reversed order (adder is the fall-through), isolation off
    alu_core #(.W(W), .TREE_SEL(1'b0), .CHAIN_ORDER(36'h012345678), .ISOLATE(1'b0)) u_alu_core_rev (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b), .cin(cin),
        .out_valid(ov2), .result(r2), .flag_c(c2), .flag_z(z2), .flag_n(n2), .flag_v(v2));

    typedef struct {
        logic [OW-1:0] val;
        string         req;
    } exp_t;

    exp_t          sbq[$];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;
    logic [OW-1:0] last_exp = '0;

    // packed as {result, C, Z, N, V}
    function automatic logic [OW-1:0] model(input logic [3:0] o, input logic [W-1:0] x,
                                            input logic [W-1:0] y, input logic ci);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         c, v;
        c = 1'b0; v = 1'b0; r = '0;
        case (o)
            4'd0: begin
                s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
                r = s[W-1:0]; c = s[W];
                v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
            end
            4'd1: begin
                r = x - y; c = (x >= y);
                v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
            end
            4'd2: r = x & y;
            4'd3: r = x | y;
            4'd4: r = x ^ y;
            4'd5: r = ~x;
            4'd6: r = {x[0], x[W-1:1]};
            4'd7: begin r = {ci, x[W-1:1]}; c = x[0]; end
            4'd8: r = {x[W-2:0], x[W-1]};
            4'd9: begin r = {x[W-2:0], ci}; c = x[W-1]; end
            default: return '0;
        endcase
        return {r, c, (r == '0), r[W-1], v};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic ci, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = o; a = x; b = y; cin = ci;
        e.val = model(o, x, y, ci);
        e.req = req;
        last_exp = e.val;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op = 4'($urandom); a = W'($urandom); b = W'($urandom); cin = 1'($urandom);
        end
    endtask

    // monitor: pops one expected item per valid output
    always @(negedge clk) begin : monitor
        exp_t e;
        if (rst_n && ov0) begin
            if (sbq.size() == 0) begin
                check("R1", "unexpected out_valid", OW'(1), OW'(0));
            end else begin
                e = sbq.pop_front();
                check(e.req, "chain", {r0, c0, z0, n0, v0}, e.val);
                check({e.req, " R9 R10"}, "tree vs model", {r1, c1, z1, n1, v1}, e.val);
                check({e.req, " R9"}, "reversed chain vs model", {r2, c2, z2, n2, v2}, e.val);
                check("R1", "valid alignment", OW'({ov1, ov2}), OW'(2'b11));
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", "reset outputs", {r0, c0, z0, n0, v0}, '0);
        check("R11", "reset valid", OW'(ov0), OW'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 add
        drive(4'd0, 16'h7FFF, 16'h0001, 1'b0, "R2 add signed overflow");
        drive(4'd0, 16'hFFFF, 16'h0001, 1'b0, "R2 R7 add carry to zero");
        drive(4'd0, 16'h1234, 16'h1111, 1'b1, "R2 add with carry-in");
        drive(4'd0, 16'h8000, 16'h8000, 1'b1, "R2 add negative overflow");
        // R3 subtract
        drive(4'd1, 16'h0005, 16'h0005, 1'b1, "R3 R7 sub equal");
        drive(4'd1, 16'h0000, 16'h0001, 1'b0, "R3 sub borrow");
        drive(4'd1, 16'h8000, 16'h0001, 1'b1, "R3 sub overflow");
        // R4 logic
        drive(4'd2, 16'hF0F0, 16'h0FF0, 1'b1, "R4 and");
        drive(4'd3, 16'hF000, 16'h000F, 1'b1, "R4 or");
        drive(4'd4, 16'hAAAA, 16'hAAAA, 1'b1, "R4 R7 xor to zero");
        drive(4'd5, 16'h00FF, 16'h1234, 1'b1, "R4 not");
        // R5 plain rotates
        drive(4'd6, 16'h0001, 16'h0000, 1'b1, "R5 ror wrap");
        drive(4'd8, 16'h8000, 16'h0000, 1'b1, "R5 rol wrap");
        // R6 rotates through carry
        drive(4'd7, 16'h0001, 16'h0000, 1'b0, "R6 rorc out to carry");
        drive(4'd7, 16'h0000, 16'h0000, 1'b1, "R6 rorc carry in");
        drive(4'd9, 16'h8000, 16'h0000, 1'b0, "R6 rolc out to carry");
        drive(4'd9, 16'h0000, 16'h0000, 1'b1, "R6 rolc carry in");
        // R8 undefined opcodes
        drive(4'd10, 16'hFFFF, 16'hFFFF, 1'b1, "R8 undefined 10");
        drive(4'd15, 16'h0000, 16'h0000, 1'b1, "R8 undefined 15");

        // R1 hold when idle
        drive(4'd3, 16'h1357, 16'h2468, 1'b0, "R1 last before idle");
        idle(4);
        check("R1", "idle valid", OW'(ov0), OW'(0));
        check("R1", "hold result", {r0, c0, z0, n0, v0}, last_exp);

        // random traffic with gaps, all opcodes
        for (int i = 0; i < 800; i++) begin
            logic [3:0] ro;
            ro = 4'($urandom);
            drive(ro, W'($urandom), W'($urandom), 1'($urandom), "R7 R9 random");
            if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
        end
        idle(4);
        check("R1", "queue drained", OW'(sbq.size()), OW'(0));
        check("R1", "final hold", {r0, c0, z0, n0, v0}, last_exp);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule